// File: doc/BRIEF.md
# Over-current pulse-skip controller

This block sits between a current-limit comparator and the high-side gate driver of a switching regulator. A strobe marks the start of each switching period, and the current-limit flag is sampled only on that strobe. The first over-current sample makes the block inhibit the high-side switch for that period. The inhibit then holds through the eight periods that follow.

After the skip phase, the block opens an eight-period confirmation window. An over-current sample inside that window asks the supervisor to latch a fault. A quiet window returns the block to normal operation. While soft-start is still running, the fault request is masked. In that case, a detection in the window starts a fresh skip phase instead. Once raised, the fault request holds until reset.

Top module: `ocp_skip_ctrl`

## Requirements
- R1: With `rst_n` low at a rising edge, `hs_inhibit` and `fault_req` are both 0 after that edge.
- R2: `ilim_det` is only looked at on edges where `cyc_start` is 1. A high `ilim_det` with no strobe changes neither output.
- R3: When the block is not inhibiting and a strobe sees `ilim_det` high, `hs_inhibit` is 1 after that edge.
- R4: After a first detection, `hs_inhibit` stays 1 through the next 8 strobes. It returns to 0 after the 9th strobe if `ilim_det` is low on that strobe.
- R5: A strobe numbered 9 through 16 after the first detection that sees `ilim_det` high, with `ss_done` at 1, sets `fault_req` to 1 after that edge. Both boundary strobes, 9 and 16, count.
- R6: If strobes 9 through 16 all see `ilim_det` low, the block returns to normal. A detection on strobe 17 is then treated as a new first detection: it inhibits and raises no fault.
- R7: While `ss_done` is 0, no fault is raised. A detection in the window instead restarts the skip phase, so `hs_inhibit` is 1 for another 8 strobes.
- R8: Once `fault_req` is 1, it stays 1 until reset, whatever the other inputs do, and `hs_inhibit` is 1 with it.
- R9: A detection on strobes 1 through 8 of the skip phase neither lengthens nor shortens it.
- R10: The period count advances only on edges where `cyc_start` is 1. Clock edges between strobes do not move the skip phase or the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| ilim_det | input | 1 | Current-limit flag, sampled on the strobe |
| ss_done | input | 1 | 1 once soft-start is past its threshold; enables the fault request |
| hs_inhibit | output | 1 | 1 blocks the high-side drive |
| fault_req | output | 1 | Latched fault request to the supervisor |

## Verification
Both outputs are decoded straight from one state register, so every result is due exactly one rising edge after the strobe or reset that causes it. Gap clocks without a strobe must leave both outputs unchanged. The driver changes inputs on falling edges and queues one expected pair of outputs per clock. The monitor pops one item one time unit after each rising edge, so each expectation is compared against the edge that consumed its stimulus. Skip phases are run with idle clocks between strobes, so that a count advancing on every clock would end the inhibit early.

// File: rtl/ocp_skip_pkg.sv
// Shared types for the over-current pulse-skip controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ocp_skip_pkg;

    // Controller phase: normal, skipping, confirmation window, latched fault
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_WATCH = 2'd2,
        ST_FAULT = 2'd3
    } ocp_state_e;

endpackage

// File: rtl/ocp_cycle_counter.sv
// Counts switching-period strobes since the last over-current detection.
// Assumes: clr has priority over adv; the caller keeps the count below 2**CNT_W.
module ocp_cycle_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] count
);

    // Purpose: clear or step the period count
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (adv) count <= count + 1'b1;
    end

endmodule

// File: rtl/ocp_skip_fsm.sv
// Phase sequencer: first detection -> skip phase -> confirmation window -> idle or fault.
// Assumes: count holds the number of strobes seen since the detection that opened
// the sequence; decisions are taken only on edges where cyc_start is high.
module ocp_skip_fsm
    import ocp_skip_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             ilim_det,
    input  logic             ss_done,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_adv,
    output ocp_state_e       state
);

    localparam logic [CNT_W:0] WIN_FIRST = (CNT_W+1)'(SKIP_CYCLES + 1);
    localparam logic [CNT_W:0] WIN_LAST  = (CNT_W+1)'(SKIP_CYCLES + WATCH_CYCLES);

    ocp_state_e     state_nxt;
    logic [CNT_W:0] strobe_no;
    logic           in_window;

    // Purpose: number of the period this strobe opens, and whether it lies in the window
    always_comb begin
        strobe_no = {1'b0, count} + 1'b1;
        in_window = (state == ST_WATCH) ||
                    ((state == ST_SKIP) && (strobe_no == WIN_FIRST));
    end

    // Purpose: next phase and counter control for this strobe
    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_adv   = 1'b0;
        if (cyc_start) begin
            if (state == ST_IDLE) begin
                if (ilim_det) begin
                    state_nxt = ST_SKIP;
                    cnt_clr   = 1'b1;
                end
            end else if (in_window) begin
                if (ilim_det && ss_done) begin
                    state_nxt = ST_FAULT;
                end else if (ilim_det) begin
                    state_nxt = ST_SKIP;
                    cnt_clr   = 1'b1;
                end else if (strobe_no == WIN_LAST) begin
                    state_nxt = ST_IDLE;
                    cnt_clr   = 1'b1;
                end else begin
                    state_nxt = ST_WATCH;
                    cnt_adv   = 1'b1;
                end
            end else if (state == ST_SKIP) begin
                cnt_adv = 1'b1;
            end
        end
    end

    // Purpose: phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/ocp_skip_ctrl.sv
// Top of the over-current pulse-skip controller.
// Assumes: cyc_start is a single-clock strobe per switching period and ilim_det is
// already synchronous to clk. Outputs are decoded from the registered phase only.
module ocp_skip_ctrl
    import ocp_skip_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = $clog2(SKIP_CYCLES + WATCH_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic ilim_det,
    input  logic ss_done,
    output logic hs_inhibit,
    output logic fault_req
);

    logic [CNT_W-1:0] count;
    logic             cnt_clr;
    logic             cnt_adv;
    ocp_state_e       state;

    ocp_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (cnt_adv),
        .count (count)
    );

    ocp_skip_fsm #(
        .SKIP_CYCLES  (SKIP_CYCLES),
        .WATCH_CYCLES (WATCH_CYCLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .ilim_det  (ilim_det),
        .ss_done   (ss_done),
        .count     (count),
        .cnt_clr   (cnt_clr),
        .cnt_adv   (cnt_adv),
        .state     (state)
    );

    // Purpose: glitch-free outputs from the phase register
    always_comb begin
        hs_inhibit = (state == ST_SKIP) || (state == ST_FAULT);
        fault_req  = (state == ST_FAULT);
    end

endmodule

// File: rtl/ocp_skip_ctrl_chk.sv
// Port-level properties of the pulse-skip controller, bound to every instance.
// Assumes: synchronous active-low reset.
module ocp_skip_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic ilim_det,
    input logic ss_done,
    input logic hs_inhibit,
    input logic fault_req
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!hs_inhibit && !fault_req)); // R1

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> ($stable(hs_inhibit) && $stable(fault_req))); // R10

    AST_FIRST_DETECT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && ilim_det && !hs_inhibit) |=> hs_inhibit); // R3

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |=> fault_req); // R8

    AST_FAULT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> hs_inhibit); // R8

    AST_MASKED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_done && !fault_req) |=> !fault_req); // R7

endmodule

bind ocp_skip_ctrl ocp_skip_ctrl_chk u_chk (.*);

// File: tb/ocp_skip_ctrl_test.sv
// Scoreboard bench: the driver queues one expectation per clock, the monitor
// compares it one time unit after the rising edge that consumed the stimulus.
module ocp_skip_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  inh;
        logic  flt;
        string tag;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic ilim_det = 1'b0;
    logic ss_done = 1'b0;
    logic hs_inhibit;
    logic fault_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic exp_inh = 1'b0;
    logic exp_flt = 1'b0;
    sb_item_t sb_q[$];

    ocp_skip_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .ilim_det   (ilim_det),
        .ss_done    (ss_done),
        .hs_inhibit (hs_inhibit),
        .fault_req  (fault_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one clock of stimulus and queue the expected outputs
    task automatic tick(input logic r, input logic cs, input logic il,
                        input logic ss, input string tag);
        @(negedge clk);
        rst_n = r; cyc_start = cs; ilim_det = il; ss_done = ss;
        sb_q.push_back('{exp_inh, exp_flt, tag});
    endtask

    // Eight skip strobes with idle clocks between them, some with the flag high
    task automatic skip_run(input logic ss);
        exp_inh = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            tick(1'b1, 1'b1, (i % 3) == 0, ss, "R9");
            tick(1'b1, 1'b0, 1'b1, ss, "R10");
        end
    endtask

    // Monitor: pop and compare away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (hs_inhibit !== it.inh || fault_req !== it.flt) begin
                    bad++;
                    $display("FAIL %s: inh=%b flt=%b expected inh=%b flt=%b",
                             it.tag, hs_inhibit, fault_req, it.inh, it.flt);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        exp_inh = 0; exp_flt = 0;
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        tick(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2: flag without strobe is ignored
        repeat (3) tick(1'b1, 1'b0, 1'b1, 1'b1, "R2");

        // R3/R4: first detection, skip, then quiet window (R6)
        exp_inh = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        skip_run(1'b1);
        exp_inh = 0; tick(1'b1, 1'b1, 1'b0, 1'b1, "R4");
        for (int s = 10; s <= 16; s++) begin
            tick(1'b1, 1'b1, 1'b0, 1'b1, "R6");
            tick(1'b1, 1'b0, 1'b1, 1'b1, "R2");
        end
        // R6: strobe 17 is a fresh first detection
        exp_inh = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R6");

        // R7: masked detection in window restarts skipping
        skip_run(1'b1);
        exp_inh = 0; tick(1'b1, 1'b1, 1'b0, 1'b0, "R4");
        tick(1'b1, 1'b1, 1'b0, 1'b0, "R4");
        tick(1'b1, 1'b1, 1'b0, 1'b0, "R4");
        exp_inh = 1; tick(1'b1, 1'b1, 1'b1, 1'b0, "R7");
        skip_run(1'b0);
        exp_inh = 0; tick(1'b1, 1'b1, 1'b0, 1'b1, "R7");
        repeat (3) tick(1'b1, 1'b1, 1'b0, 1'b1, "R4");
        // R5: detection mid-window with soft-start done
        exp_inh = 1; exp_flt = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        // R8: fault holds
        repeat (4) tick(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        repeat (2) tick(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        exp_inh = 0; exp_flt = 0; tick(1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R5: boundary at strobe 9
        exp_inh = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        skip_run(1'b1);
        exp_flt = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        exp_inh = 0; exp_flt = 0; tick(1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R5: boundary at strobe 16
        exp_inh = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        skip_run(1'b1);
        exp_inh = 0;
        for (int s = 9; s <= 15; s++) tick(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        exp_inh = 1; exp_flt = 1; tick(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        tick(1'b1, 1'b0, 1'b0, 1'b1, "R8");

        @(negedge clk); cyc_start = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule